// File: doc/BRIEF.md
# Serial CRC Generator and Checker

This block computes a cyclic redundancy check one bit per clock by running binary polynomial long division in a shift register. Each accepted bit is shifted into the bottom of the register. Whenever the bit leaving the top is a one, the divisor's low coefficients are XORed into the shifted value. The same datapath serves both to produce a check value and to verify a frame that already carries one.

To produce a check value, the user shifts in the message most significant bit first, followed by as many zero bits as the CRC width. The register then holds the remainder, which goes in place of those zeros in the transmitted frame. To verify a frame, the user shifts in the message followed by its remainder with the check mode selected. The frame is good when the register ends at zero.

A parameter picks a preset: a 4-bit example divisor, CRC-16, CRC-32, or a custom width, divisor and seed.

Top module: `serial_crc_unit`

## Requirements
- R1: While reset is low, the register holds the preset seed asynchronously: all ones for the CRC-32 preset (PRESET=2), zero for the 4-bit preset (PRESET=0) and the CRC-16 preset (PRESET=1).
- R2: With `init` high at a rising edge, the register loads the preset seed on that edge, even when `din_valid` is also high.
- R3: When `din_valid` and `init` are both low, the register keeps its value at every edge.
- R4: On an edge with `din_valid` high and `init` low, the register shifts left with `din` entering bit 0. If the old top bit was 1, the divisor's low coefficients are XORed in. `remainder` shows the result one clock after the bit.
- R5: With the 4-bit preset (divisor x^4+x+1), message 1011001 followed by 0000 leaves remainder 1010, passing through 1,2,5,B,5,A,6,C,B,5,A (hex) bit by bit.
- R6: `crc_ok` is high exactly when `mode_chk` is 1 (check mode) and the register is all zeros, combinationally. It is low whenever `mode_chk` is 0 (generate mode).
- R7: In check mode, a frame of message plus its generated remainder leaves `crc_ok` high. The frame 10110011010 passes with the 4-bit preset. Flipping any single bit, or any burst of width 4 or fewer bits, leaves `crc_ok` low.
- R8: The CRC-16 preset divides by x^16+x^15+x^2+1 (low coefficients 0x8005). The CRC-32 preset divides by the 32-degree generator with low coefficients 0x04C11DB7 and is seeded with all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| init | input | 1 | Load the preset seed on the next edge |
| din | input | 1 | Serial bit, most significant first |
| din_valid | input | 1 | `din` is accepted on this edge |
| mode_chk | input | 1 | 1 = check mode, 0 = generate mode |
| remainder | output | CW | Current register contents (width set by the preset) |
| crc_ok | output | 1 | Check mode and all-zero register |

## Verification
Each accepted bit and each `init` changes `remainder` at the next rising edge. The bench therefore drives inputs on the falling edge and reads `remainder` one nanosecond after the following rising edge. `crc_ok` follows the register within the same cycle, so it is read at the same point as the last frame bit's remainder. After `rst_n` rises, the internal reset is released two edges later, and the bench waits three cycles before the first stimulus. Expected remainders for the long presets come from a textbook long division over a bit array in the bench. The worked 4-bit case is checked against its known intermediate values.

// File: rtl/crc_pkg.sv
package crc_pkg;

  localparam int unsigned PRESET_TEACH4 = 0;
  localparam int unsigned PRESET_CRC16  = 1;
  localparam int unsigned PRESET_CRC32  = 2;
  localparam int unsigned PRESET_CUSTOM = 3;

  function automatic int unsigned crc_width(input int unsigned preset,
                                            input int unsigned custom_w);
    case (preset)
      PRESET_TEACH4: return 4;
      PRESET_CRC16:  return 16;
      PRESET_CRC32:  return 32;
      default:       return custom_w;
    endcase
  endfunction

  // low coefficients of the divisor; the leading term is implied
  function automatic logic [63:0] crc_taps(input int unsigned preset,
                                           input logic [63:0] custom_taps);
    case (preset)
      PRESET_TEACH4: return 64'h3;
      PRESET_CRC16:  return 64'h8005;
      PRESET_CRC32:  return 64'h04C1_1DB7;
      default:       return custom_taps;
    endcase
  endfunction

  function automatic logic [63:0] crc_seed(input int unsigned preset,
                                           input logic [63:0] custom_seed);
    case (preset)
      PRESET_TEACH4: return 64'h0;
      PRESET_CRC16:  return 64'h0;
      PRESET_CRC32:  return 64'hFFFF_FFFF;
      default:       return custom_seed;
    endcase
  endfunction

endpackage

// File: rtl/crc_rst_sync.sv
module crc_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/crc_div_step.sv
module crc_div_step #(
  parameter int unsigned W    = 4,
  parameter logic [W-1:0] TAPS = '0
) (
  input  logic [W-1:0] cur,
  input  logic         bit_in,
  output logic [W-1:0] nxt
);
  logic top_bit;
  assign top_bit = cur[W-1];

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic shifted;
    if (i == 0) begin : g_lsb
      assign shifted = bit_in;
    end else begin : g_up
      assign shifted = cur[i-1];
    end
    if (TAPS[i]) begin : g_tap
      assign nxt[i] = shifted ^ top_bit;
    end else begin : g_pass
      assign nxt[i] = shifted;
    end
  end
endmodule

// File: rtl/crc_state_reg.sv
module crc_state_reg #(
  parameter int unsigned W    = 4,
  parameter logic [W-1:0] SEED = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_seed,
  input  logic         shift_en,
  input  logic [W-1:0] shift_val,
  output logic [W-1:0] q
);
  logic [W-1:0] d;
  logic         en;

  always_comb begin
    en = load_seed | shift_en;
    d  = q;
    if (load_seed)     d = SEED;
    else if (shift_en) d = shift_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= SEED;
    else if (en) q <= d;
  end

  // R2
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_seed |=> (q == SEED));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_seed && !shift_en) |=> $stable(q));
endmodule

// File: rtl/crc_zero_flag.sv
module crc_zero_flag #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] vec,
  input  logic         enable,
  output logic         flag
);
  assign flag = enable && (vec == '0);
endmodule

// File: rtl/serial_crc_unit.sv
module serial_crc_unit
  import crc_pkg::*;
#(
  parameter int unsigned  PRESET       = 0,
  parameter int unsigned  CUSTOM_WIDTH = 8,
  parameter logic [63:0]  CUSTOM_TAPS  = 64'h07,
  parameter logic [63:0]  CUSTOM_SEED  = 64'h0,
  localparam int unsigned CW = crc_width(PRESET, CUSTOM_WIDTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          din,
  input  logic          din_valid,
  input  logic          mode_chk,
  output logic [CW-1:0] remainder,
  output logic          crc_ok
);
  localparam logic [63:0]   TAPS_ALL = crc_taps(PRESET, CUSTOM_TAPS);
  localparam logic [63:0]   SEED_ALL = crc_seed(PRESET, CUSTOM_SEED);
  localparam logic [CW-1:0] TAPS     = TAPS_ALL[CW-1:0];
  localparam logic [CW-1:0] SEED     = SEED_ALL[CW-1:0];

  logic          rst_sync_n;
  logic          shift_en;
  logic [CW-1:0] step_val;

  assign shift_en = din_valid & ~init;

  crc_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  crc_div_step #(.W(CW), .TAPS(TAPS)) u_step (
    .cur    (remainder),
    .bit_in (din),
    .nxt    (step_val)
  );

  crc_state_reg #(.W(CW), .SEED(SEED)) u_reg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_seed (init),
    .shift_en  (shift_en),
    .shift_val (step_val),
    .q         (remainder)
  );

  crc_zero_flag #(.W(CW)) u_zero (
    .vec    (remainder),
    .enable (mode_chk),
    .flag   (crc_ok)
  );

  // R4
  shift_plain_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (shift_en && !remainder[CW-1]) |=>
      (remainder == {$past(remainder[CW-2:0]), $past(din)}));

  // R4
  shift_reduce_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (shift_en && remainder[CW-1]) |=>
      (remainder == ({$past(remainder[CW-2:0]), $past(din)} ^ TAPS)));

  // R6
  ok_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    crc_ok |-> (remainder == '0));

  // R6
  gen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mode_chk |-> !crc_ok);
endmodule

// File: tb/serial_crc_unit_tb_top.sv
module serial_crc_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init = 1'b0;
  logic din = 1'b0;
  logic din_valid = 1'b0;
  logic mode_chk = 1'b0;
  logic [3:0]  rem4;
  logic [15:0] rem16;
  logic [31:0] rem32;
  logic ok4, ok16, ok32;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic fr [0:127];
  int   flen;

  localparam logic [3:0] WORKED_STEPS [11] =
    '{4'h1, 4'h2, 4'h5, 4'hB, 4'h5, 4'hA, 4'h6, 4'hC, 4'hB, 4'h5, 4'hA};

  always #5 clk = ~clk;

  serial_crc_unit #(.PRESET(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .init(init), .din(din), .din_valid(din_valid),
    .mode_chk(mode_chk), .remainder(rem4), .crc_ok(ok4));

  serial_crc_unit #(.PRESET(1)) dut16_i (
    .clk(clk), .rst_n(rst_n), .init(init), .din(din), .din_valid(din_valid),
    .mode_chk(mode_chk), .remainder(rem16), .crc_ok(ok16));

  serial_crc_unit #(.PRESET(2)) dut32_i (
    .clk(clk), .rst_n(rst_n), .init(init), .din(din), .din_valid(din_valid),
    .mode_chk(mode_chk), .remainder(rem32), .crc_ok(ok32));

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // textbook long division over [seed bits, frame bits]
  function automatic logic [31:0] ref_rem(input int w, input logic [63:0] gen,
                                          input logic [31:0] seed);
    logic a [0:191];
    int n;
    logic [31:0] r;
    n = w + flen;
    for (int k = 0; k < w; k++)    a[k] = seed[w-1-k];
    for (int k = 0; k < flen; k++) a[w+k] = fr[k];
    for (int i = 0; i < n - w; i++)
      if (a[i])
        for (int j = 0; j <= w; j++) a[i+j] = a[i+j] ^ gen[w-j];
    r = '0;
    for (int k = 0; k < w; k++) r[w-1-k] = a[n-w+k];
    return r;
  endfunction

  task automatic push_bit(input logic b);
    @(negedge clk);
    din = b;
    din_valid = 1'b1;
    init = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic go_idle();
    @(negedge clk);
    din_valid = 1'b0;
    din = 1'b0;
  endtask

  task automatic do_init();
    @(negedge clk);
    init = 1'b1;
    din_valid = 1'b0;
    @(posedge clk);
    #1;
    @(negedge clk);
    init = 1'b0;
  endtask

  task automatic send_frame();
    for (int k = 0; k < flen; k++) push_bit(fr[k]);
  endtask

  task automatic load_bits(input logic [63:0] v, input int nb, input int at);
    for (int k = 0; k < nb; k++) fr[at+k] = v[nb-1-k];
  endtask

  task automatic t_reset();
    mode_chk = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset 4-bit seed", rem4, 64'h0);
    check("R1 reset crc32 seed", rem32, 64'hFFFF_FFFF);
    check("R6 ok on zero register", ok4, 1);
    check("R6 ok low on nonzero register", ok32, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", rem4, 64'h0);
  endtask

  task automatic t_worked();
    logic [10:0] bits;
    mode_chk = 1'b0;
    do_init();
    bits = 11'b1011001_0000;
    for (int k = 0; k < 11; k++) begin
      push_bit(bits[10-k]);
      check($sformatf("R4 R5 worked step %0d", k), rem4, WORKED_STEPS[k]);
    end
    check("R5 worked remainder", rem4, 64'hA);
    check("R6 generate mode keeps ok low", ok4, 0);
    go_idle();
  endtask

  task automatic t_hold();
    repeat (5) @(negedge clk);
    check("R3 idle hold", rem4, 64'hA);
    din = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 din ignored without valid", rem4, 64'hA);
    din = 1'b0;
  endtask

  task automatic t_init_priority();
    @(negedge clk);
    init = 1'b1;
    din_valid = 1'b1;
    din = 1'b1;
    @(posedge clk);
    #1;
    check("R2 init over valid 4-bit", rem4, 64'h0);
    check("R2 R8 init over valid crc32", rem32, 64'hFFFF_FFFF);
    @(negedge clk);
    init = 1'b0;
    din_valid = 1'b0;
    din = 1'b0;
  endtask

  task automatic t_check_frame();
    mode_chk = 1'b1;
    do_init();
    flen = 11;
    load_bits(64'b10110011010, 11, 0);
    send_frame();
    check("R7 good frame passes", ok4, 1);
    check("R7 good frame zero remainder", rem4, 64'h0);
    go_idle();
  endtask

  task automatic t_errors();
    logic [10:0] base;
    logic [10:0] err;
    int npat;
    base = 11'b10110011010;
    mode_chk = 1'b1;
    for (int len = 1; len <= 4; len++) begin
      npat = (len > 2) ? (1 << (len - 2)) : 1;
      for (int st = 0; st + len <= 11; st++) begin
        for (int p = 0; p < npat; p++) begin
          err = '0;
          err[st] = 1'b1;
          err[st+len-1] = 1'b1;
          for (int m = 1; m < len - 1; m++) err[st+m] = p[m-1];
          flen = 11;
          load_bits({53'b0, base ^ err}, 11, 0);
          do_init();
          send_frame();
          check($sformatf("R7 burst len %0d at %0d pat %0d", len, st, p), ok4, 0);
          go_idle();
        end
      end
    end
  endtask

  task automatic t_crc16();
    logic [31:0] exp;
    mode_chk = 1'b0;
    do_init();
    flen = 32;
    load_bits(64'h1234, 16, 0);
    load_bits(64'h0, 16, 16);
    exp = ref_rem(16, 64'h1_8005, 32'h0);
    send_frame();
    check("R8 crc16 remainder", rem16, {32'h0, exp});
    go_idle();
    mode_chk = 1'b1;
    do_init();
    load_bits({48'h0, exp[15:0]}, 16, 16);
    send_frame();
    check("R7 R8 crc16 frame passes", ok16, 1);
    go_idle();
  endtask

  task automatic t_crc32();
    logic [31:0] exp;
    mode_chk = 1'b0;
    do_init();
    flen = 48;
    load_bits(64'hA5C3, 16, 0);
    load_bits(64'h0, 32, 16);
    exp = ref_rem(32, 64'h1_04C1_1DB7, 32'hFFFF_FFFF);
    send_frame();
    check("R8 crc32 remainder", rem32, {32'h0, exp});
    go_idle();
    mode_chk = 1'b1;
    do_init();
    load_bits({32'h0, exp}, 32, 16);
    send_frame();
    check("R7 R8 crc32 frame passes", ok32, 1);
    fr[20] = ~fr[20];
    do_init();
    send_frame();
    check("R7 crc32 flipped bit fails", ok32, 0);
    go_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_worked();
    t_hold();
    t_init_priority();
    t_check_frame();
    t_errors();
    t_crc16();
    t_crc32();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule